// File: doc/BRIEF.md
# Interrupt Stack Frame Push Sequencer

This block writes an interrupt or exception frame onto the handler stack once the handler has been chosen. A single start pulse captures all of its inputs: the operating mode, the legacy gate size, whether the privilege level changes, the interrupted context (stack selector, stack pointer, flags, code selector, instruction pointer), the stack pointer to switch to, an optional error code and the kind of event. The block then issues one store per accepted cycle on a valid/ready write port. Each store carries an address, zero-extended data and a byte size.

The frame is pushed in this order: stack selector, stack pointer, flags, code selector, instruction pointer, then the error code. Each store first lowers the working stack pointer by the push width. In 64-bit mode every push is eight bytes, the stack pair is always pushed, and the starting pointer is aligned down to 16 bytes. In legacy mode the push width follows the gate (two or four bytes), and the stack pair is pushed only on a privilege change. When the frame is complete the block pulses `done` and presents the resulting stack pointer and the stack selector the handler will run with.

Top module: `intr_frame_pusher`

## Requirements
- R1: `start` is taken only while `busy` is low, and all frame inputs are captured at that edge. A `start` that arrives while a frame is in progress has no effect on the stores or on the results.
- R2: With `longMode`=1, every store has `wrSize`=8, and the starting pointer has its low four bits cleared before the first push.
- R3: The stores follow the order stack selector, old stack pointer, flags, code selector, instruction pointer, error code. Any store that is not required is omitted. With `longMode`=1 the stack selector and stack pointer are always stored.
- R4: With `longMode`=0, the stack selector and stack pointer are stored only when `cplChange`=1.
- R5: With `longMode`=0, the push width is 4 bytes when `gateWide`=1 and 2 bytes when `gateWide`=0, and this includes the error code. Store data keeps only the low width*8 bits of the value, and all upper bits are zero.
- R6: The error code is stored only when `errValid`=1 and `evtSrc`=0 (an event detected internally). Codes 1 (external interrupt pin), 2 (software INT n) and 3 never push an error code.
- R7: The working pointer starts from `newRsp` when `cplChange`=1 and from `oldRsp` otherwise.
- R8: Each store address equals the previous working pointer minus `wrSize`. `finalRsp` equals the address of the last store.
- R9: While `wrValid`=1 and `wrReady`=0, the address, data and size stay unchanged, and no store is skipped or repeated.
- R10: `done` is high for exactly one cycle, in the cycle after the last store is accepted. From that cycle until the next start, `finalRsp` and `finalSs` hold the frame results.
- R11: `finalSs` is 0 when `longMode`=1 and `cplChange`=1. It is `newSs` when `longMode`=0 and `cplChange`=1, and `oldSs` when `cplChange`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken when idle) |
| longMode | input | 1 | 1 = 64-bit rules, 0 = legacy rules |
| gateWide | input | 1 | Legacy gate size: 1 = 32-bit, 0 = 16-bit |
| cplChange | input | 1 | Privilege level changes on entry |
| evtSrc | input | 2 | 0 internal, 1 external pin, 2 software INT n, 3 other |
| errValid | input | 1 | The vector carries an error code |
| errCode | input | 32 | Error code value |
| oldSs | input | 16 | Interrupted stack selector |
| oldRsp | input | 64 | Interrupted stack pointer |
| oldRflags | input | 64 | Interrupted flags |
| oldCs | input | 16 | Interrupted code selector |
| oldRip | input | 64 | Interrupted instruction pointer |
| newRsp | input | 64 | Stack pointer used on a privilege change |
| newSs | input | 16 | Stack selector used on a legacy privilege change |
| wrValid | output | 1 | Store request valid |
| wrReady | input | 1 | Store accepted when high with wrValid |
| wrAddr | output | 64 | Store byte address |
| wrData | output | 64 | Store data, zero-extended |
| wrSize | output | 4 | Store size in bytes (2, 4 or 8) |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| finalRsp | output | 64 | Stack pointer after the frame |
| finalSs | output | 16 | Stack selector for the handler |

## Verification
Two things can happen in the same cycle: a store being held by back-pressure, and a new `start` arriving while the frame is in progress. The bench raises `start` with scrambled inputs in the middle of a 64-bit frame, while `wrReady` is driven by a pseudo-random pattern. A reference model runs every cycle with a queue of expected stores and checks that the stalled store stays put, that the late start leaves the remaining stores and results unchanged, and that `done` still appears exactly one cycle after the final acceptance.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  typedef enum logic [2:0] {
    STEP_SS    = 3'd0,
    STEP_RSP   = 3'd1,
    STEP_FLAGS = 3'd2,
    STEP_CS    = 3'd3,
    STEP_RIP   = 3'd4,
    STEP_ERR   = 3'd5
  } stepT;

  localparam logic [1:0] SRC_INTERNAL = 2'd0;

  typedef struct packed {
    logic load;
    logic advance;
    stepT step;
  } ctrlStrobeT;
endpackage

// File: rtl/ifp_ctrl.sv
module ifp_ctrl
  import ifp_pkg::*;
#(
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             longMode,
  input  logic             cplChange,
  input  logic             errValid,
  input  logic [SRC_W-1:0] evtSrc,
  input  logic             wrReady,
  output ctrlStrobeT       strobe,
  output logic             wrValid,
  output logic             busy,
  output logic             done
);
  logic running;
  stepT step;
  logic pushErrQ;
  logic doneQ;
  logic accept;
  logic atLast;
  stepT firstStep;
  stepT lastStep;

  assign firstStep = (longMode || cplChange) ? STEP_SS : STEP_FLAGS;
  assign lastStep  = pushErrQ ? STEP_ERR : STEP_RIP;
  assign accept    = running && wrReady;
  assign atLast    = (step == lastStep);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      step     <= STEP_SS;
      pushErrQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= accept && atLast;
      if (start && !running) begin
        running  <= 1'b1;
        step     <= firstStep;
        pushErrQ <= errValid && (evtSrc == SRC_W'(SRC_INTERNAL));
      end else if (accept) begin
        if (atLast) running <= 1'b0;
        else        step    <= stepT'(step + 3'd1);
      end
    end
  end

  assign strobe.load    = start && !running;
  assign strobe.advance = accept;
  assign strobe.step    = step;
  assign wrValid        = running;
  assign busy           = running;
  assign done           = doneQ;

  // R9: a stalled store keeps its position in the sequence
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(step)));

  // R10: completion only follows an accepted store
  p_done_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrValid && wrReady));

  // R10: the pulse lasts one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: a start during a frame does not restart the step
  p_no_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && !wrReady) |=> $stable(step));
endmodule

// File: rtl/ifp_datapath.sv
module ifp_datapath
  import ifp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int SEL_W  = 16,
  parameter int ERR_W  = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic              wrValid,
  input  logic              wrReady,
  input  logic              done,
  input  logic              longMode,
  input  logic              gateWide,
  input  logic              cplChange,
  input  logic [ERR_W-1:0]  errCode,
  input  logic [SEL_W-1:0]  oldSs,
  input  logic [ADDR_W-1:0] oldRsp,
  input  logic [DATA_W-1:0] oldRflags,
  input  logic [SEL_W-1:0]  oldCs,
  input  logic [ADDR_W-1:0] oldRip,
  input  logic [ADDR_W-1:0] newRsp,
  input  logic [SEL_W-1:0]  newSs,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [SIZE_W-1:0] wrSize,
  output logic [ADDR_W-1:0] finalRsp,
  output logic [SEL_W-1:0]  finalSs
);
  localparam int ALIGN_BITS = 4;

  logic              modeQ, wideQ, cplQ;
  logic [SEL_W-1:0]  ssQ, csQ, finalSsQ;
  logic [ADDR_W-1:0] rspQ, ripQ, spQ;
  logic [DATA_W-1:0] flagsQ;
  logic [ERR_W-1:0]  errQ;
  logic [ADDR_W-1:0] baseSp;
  logic [ADDR_W-1:0] startSp;
  logic [SEL_W-1:0]  nextSs;
  logic [DATA_W-1:0] rawData;
  logic [DATA_W-1:0] widthMask;

  assign baseSp  = cplChange ? newRsp : oldRsp;
  assign startSp = longMode ? {baseSp[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}} : baseSp;

  always_comb begin
    if (!cplChange)    nextSs = oldSs;
    else if (longMode) nextSs = '0;
    else               nextSs = newSs;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      wideQ    <= 1'b0;
      cplQ     <= 1'b0;
      ssQ      <= '0;
      csQ      <= '0;
      rspQ     <= '0;
      ripQ     <= '0;
      flagsQ   <= '0;
      errQ     <= '0;
      spQ      <= '0;
      finalSsQ <= '0;
    end else if (strobe.load) begin
      modeQ    <= longMode;
      wideQ    <= gateWide;
      cplQ     <= cplChange;
      ssQ      <= oldSs;
      csQ      <= oldCs;
      rspQ     <= oldRsp;
      ripQ     <= oldRip;
      flagsQ   <= oldRflags;
      errQ     <= errCode;
      spQ      <= startSp;
      finalSsQ <= nextSs;
    end else if (strobe.advance) begin
      spQ <= wrAddr;
    end
  end

  always_comb begin
    if (modeQ)      wrSize = SIZE_W'(8);
    else if (wideQ) wrSize = SIZE_W'(4);
    else            wrSize = SIZE_W'(2);
  end

  always_comb begin
    case (wrSize)
      SIZE_W'(8): widthMask = '1;
      SIZE_W'(4): widthMask = DATA_W'({32{1'b1}});
      default:    widthMask = DATA_W'({16{1'b1}});
    endcase
  end

  always_comb begin
    case (strobe.step)
      STEP_SS:    rawData = DATA_W'(ssQ);
      STEP_RSP:   rawData = DATA_W'(rspQ);
      STEP_FLAGS: rawData = flagsQ;
      STEP_CS:    rawData = DATA_W'(csQ);
      STEP_RIP:   rawData = DATA_W'(ripQ);
      default:    rawData = DATA_W'(errQ);
    endcase
  end

  assign wrData   = rawData & widthMask;
  assign wrAddr   = spQ - ADDR_W'(wrSize);
  assign finalRsp = spQ;
  assign finalSs  = finalSsQ;

  // R9: a stalled store keeps its payload
  p_payload_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ($stable(wrAddr) && $stable(wrData) && $stable(wrSize)));

  // R2: 64-bit stores are eight bytes at eight-byte addresses
  p_long_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && modeQ) |-> (wrSize == SIZE_W'(8) && wrAddr[2:0] == 3'd0));

  // R8: consecutive stores in one frame are adjacent
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=> (!wrValid || wrAddr == $past(wrAddr) - ADDR_W'($past(wrSize))));

  // R5: narrow legacy stores carry no upper bits
  p_narrow_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !modeQ && !wideQ) |-> (wrData[DATA_W-1:16] == '0));

  // R11: 64-bit privilege change yields the null selector
  p_null_ss_r11: assert property (@(posedge clk) disable iff (!rstN)
    (done && modeQ && cplQ) |-> (finalSs == '0));
endmodule

// File: rtl/intr_frame_pusher.sv
module intr_frame_pusher
  import ifp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int SEL_W  = 16,
  parameter int ERR_W  = 32,
  parameter int SRC_W  = 2,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              longMode,
  input  logic              gateWide,
  input  logic              cplChange,
  input  logic [SRC_W-1:0]  evtSrc,
  input  logic              errValid,
  input  logic [ERR_W-1:0]  errCode,
  input  logic [SEL_W-1:0]  oldSs,
  input  logic [ADDR_W-1:0] oldRsp,
  input  logic [DATA_W-1:0] oldRflags,
  input  logic [SEL_W-1:0]  oldCs,
  input  logic [ADDR_W-1:0] oldRip,
  input  logic [ADDR_W-1:0] newRsp,
  input  logic [SEL_W-1:0]  newSs,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [SIZE_W-1:0] wrSize,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] finalRsp,
  output logic [SEL_W-1:0]  finalSs
);
  ctrlStrobeT strobe;

  ifp_ctrl #(.SRC_W(SRC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .longMode(longMode),
    .cplChange(cplChange), .errValid(errValid), .evtSrc(evtSrc),
    .wrReady(wrReady), .strobe(strobe), .wrValid(wrValid),
    .busy(busy), .done(done)
  );

  ifp_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .ERR_W(ERR_W), .SIZE_W(SIZE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrValid(wrValid),
    .wrReady(wrReady), .done(done), .longMode(longMode),
    .gateWide(gateWide), .cplChange(cplChange), .errCode(errCode),
    .oldSs(oldSs), .oldRsp(oldRsp), .oldRflags(oldRflags),
    .oldCs(oldCs), .oldRip(oldRip), .newRsp(newRsp), .newSs(newSs),
    .wrAddr(wrAddr), .wrData(wrData), .wrSize(wrSize),
    .finalRsp(finalRsp), .finalSs(finalSs)
  );
endmodule

// File: tb/sim_intr_frame_pusher.sv
`timescale 1ns/1ps
module sim_intr_frame_pusher;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0, start = 1'b0;
  logic        longMode = 1'b0, gateWide = 1'b0, cplChange = 1'b0;
  logic [1:0]  evtSrc = 2'd0;
  logic        errValid = 1'b0;
  logic [31:0] errCode = '0;
  logic [15:0] oldSs = '0, oldCs = '0, newSs = '0;
  logic [63:0] oldRsp = '0, oldRflags = '0, oldRip = '0, newRsp = '0;
  logic        wrValid, wrReady = 1'b1;
  logic [63:0] wrAddr, wrData, finalRsp;
  logic [3:0]  wrSize;
  logic        busy, done;
  logic [15:0] finalSs;

  intr_frame_pusher u0 (
    .clk(clk), .rstN(rstN), .start(start), .longMode(longMode),
    .gateWide(gateWide), .cplChange(cplChange), .evtSrc(evtSrc),
    .errValid(errValid), .errCode(errCode), .oldSs(oldSs),
    .oldRsp(oldRsp), .oldRflags(oldRflags), .oldCs(oldCs),
    .oldRip(oldRip), .newRsp(newRsp), .newSs(newSs),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
    .wrData(wrData), .wrSize(wrSize), .busy(busy), .done(done),
    .finalRsp(finalRsp), .finalSs(finalSs)
  );

  logic [63:0] qAddr[$];
  logic [63:0] qData[$];
  logic [3:0]  qSize[$];
  int checks = 0, fails = 0;
  bit doneExp = 0, doneNext = 0, randReady = 0, frameEnded = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [63:0] expRsp = '0, spModel;
  logic [15:0] expSs = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pushModel(input logic [63:0] val, input int w);
    logic [63:0] m;
    m = (w == 8) ? '1 : ((64'd1 << (w * 8)) - 64'd1);
    spModel = spModel - 64'(w);
    qAddr.push_back(spModel);
    qData.push_back(val & m);
    qSize.push_back(4'(w));
  endtask

  // Expected frame from the requirements (R2 to R7, R11)
  task automatic buildExp();
    int w;
    w = longMode ? 8 : (gateWide ? 4 : 2);
    spModel = cplChange ? newRsp : oldRsp;
    if (longMode) spModel[3:0] = 4'h0;
    if (longMode || cplChange) begin
      pushModel(64'(oldSs), w);
      pushModel(oldRsp, w);
    end
    pushModel(oldRflags, w);
    pushModel(64'(oldCs), w);
    pushModel(oldRip, w);
    if (errValid && evtSrc == 2'd0) pushModel(64'(errCode), w);
    expRsp = spModel;
    expSs  = !cplChange ? oldSs : (longMode ? 16'h0 : newSs);
  endtask

  task automatic cycleStep();
    bit has;
    frameEnded = doneExp;
    chk(done === doneExp, "R10", "done", 64'(done), 64'(doneExp));
    if (doneExp) begin
      chk(finalRsp === expRsp, "R8", "finalRsp", finalRsp, expRsp);
      chk(finalSs === expSs, "R11", "finalSs", 64'(finalSs), 64'(expSs));
    end
    has = (qAddr.size() != 0);
    chk(wrValid === has, "R9", "wrValid", 64'(wrValid), 64'(has));
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wrReady = randReady ? (lfsr[0] | lfsr[3]) : 1'b1;
    if (wrValid && has) begin
      chk(wrAddr === qAddr[0], "R8", "wrAddr", wrAddr, qAddr[0]);
      chk(wrData === qData[0], "R3", "wrData", wrData, qData[0]);
      chk(wrSize === qSize[0], "R2", "wrSize", 64'(wrSize), 64'(qSize[0]));
      if (wrReady) begin
        void'(qAddr.pop_front());
        void'(qData.pop_front());
        void'(qSize.pop_front());
        if (qAddr.size() == 0) doneNext = 1;
      end
    end
    doneExp = doneNext;
    doneNext = 0;
  endtask

  task automatic runFrame(input bit lm, input bit gw, input bit cpl,
                          input logic [1:0] src, input bit ev,
                          input bit rnd, input bit poke, input logic [63:0] seed);
    int n;
    randReady = rnd;
    longMode = lm; gateWide = gw; cplChange = cpl; evtSrc = src; errValid = ev;
    errCode = 32'hE000_0000 ^ seed[31:0];
    oldSs = 16'h0023 ^ seed[15:0]; oldCs = 16'h0033 ^ seed[31:16];
    newSs = 16'h0010 ^ seed[47:32];
    oldRsp = 64'h0000_7FFF_1234_5677 ^ seed;
    newRsp = 64'hFFFF_8000_0000_9F0B ^ (seed << 8);
    oldRflags = 64'h0000_0000_0024_0246 ^ (seed << 4);
    oldRip = 64'hFFFF_FFFF_8100_ABCD ^ seed;
    start = 1'b1;
    @(negedge clk);
    buildExp();
    start = 1'b0;
    cycleStep();
    n = 0;
    while (!frameEnded) begin
      if (poke && n == 1) begin
        // R1: start during a frame with scrambled inputs
        start = 1'b1; longMode = ~longMode; cplChange = ~cplChange;
        oldRip = ~oldRip; newRsp = 64'h1000;
      end
      if (poke && n == 2) start = 1'b0;
      @(negedge clk);
      cycleStep();
      n++;
      if (n > 500) begin
        chk(1'b0, "R10", "watchdog", 64'(n), 64'd0);
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
    cycleStep();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R10 global watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wrValid === 1'b0, "R10", "reset wrValid", 64'(wrValid), 64'd0);
    chk(done === 1'b0, "R10", "reset done", 64'(done), 64'd0);
    chk(busy === 1'b0, "R1", "reset busy", 64'(busy), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    cycleStep();
    // R2 R3 R6 R7: 64-bit, same privilege, internal error code
    runFrame(1, 0, 0, 2'd0, 1, 0, 0, 64'h0);
    // R3 R7 R11: 64-bit privilege change, null selector, stalls
    runFrame(1, 1, 1, 2'd0, 0, 1, 0, 64'h55);
    // R6: external pin source suppresses error code
    runFrame(1, 0, 1, 2'd1, 1, 1, 0, 64'h1F0);
    // R4 R5: legacy 32-bit gate with privilege change and error
    runFrame(0, 1, 1, 2'd0, 1, 0, 0, 64'hABC);
    // R4: legacy 32-bit, no privilege change, no stack pair
    runFrame(0, 1, 0, 2'd3, 1, 1, 0, 64'h7777);
    // R5 R6: legacy 16-bit, software INT n, no error code
    runFrame(0, 0, 1, 2'd2, 1, 0, 0, 64'h9999_0000);
    // R5 R9: legacy 16-bit, error at 2 bytes, random stalls
    runFrame(0, 0, 0, 2'd0, 1, 1, 0, 64'h1357_9BDF);
    // R1 R9: start while busy, random back-pressure
    runFrame(1, 0, 0, 2'd0, 1, 1, 1, 64'h2468_ACE0);
    // R1: back-to-back frame after the poked one is clean
    runFrame(1, 1, 1, 2'd0, 1, 1, 0, 64'hF00D);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule